// File: doc/BRIEF.md
# NAND Program/Erase Completion Waiter

This block takes over once a program or erase operation has been launched on a NAND flash device. It asks the command sequencer to send a status command, then waits for the device to finish. The finish can be seen in one of two ways: through the ready/busy pin, or, on boards where that pin is not wired, by polling status bytes until the ready bit comes up. A timeout bounds the wait. Its length is chosen from the operation type and counted in milliseconds, which a prescaler derives from the clock rate.

When the device reports ready, or when the timeout runs out, the block waits a fixed settle interval and then reads one final status byte. That byte is presented together with a pass/fail flag and a timeout flag. The results stay unchanged until the next start. Erases on devices flagged as multi-plane get a separate status command code.

Top module: `nand_op_waiter`

## Requirements
- R1: A start pulse seen while idle makes the block busy and raises a status-command request. The request and its code are held unchanged until the sequencer accepts it.
- R2: The requested command code is `CMD_STATUS_MP` (default 0x71) only for an erase with the multi-plane flag set. For every other combination it is `CMD_STATUS` (default 0x70).
- R3: In pin mode, completion is taken from `rb_ready_i` being high, and no byte read is requested before the settle interval ends.
- R4: In polling mode, byte reads are requested again and again. Each returned byte with bit 6 (the ready bit) set ends the wait, and any byte with bit 6 clear leads to another read.
- R5: The timeout is `PROG_MS` ms for a program and `ERASE_MS` ms for an erase, one ms being `CLK_KHZ` clock cycles, counted from the first cycle after the command is accepted. On expiry without ready, `timeout_o` is set and the sequence carries on to the settle and final read. In polling mode, expiry is acted on only at a returned byte.
- R6: After completion or expiry, the final read is requested only after `SETTLE_TICKS` ms have elapsed.
- R7: The final byte is shown on `status_o`. `fail_o` equals its bit 0, and `done_o` rises when it is captured.
- R8: `status_o`, `fail_o`, `timeout_o` and `done_o` hold their values from completion until the next accepted start, which clears all four.
- R9: A start pulse while busy is ignored: the operation type, plane flag and ready-source choice of the running operation are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin waiting for the launched operation |
| op_erase_i | input | 1 | 1 = erase, 0 = program (sampled at start) |
| multi_plane_i | input | 1 | Device uses the multi-plane status command for erases |
| use_rb_i | input | 1 | 1 = ready/busy pin wired, 0 = poll the status ready bit |
| cmd_valid_o | output | 1 | Status command request to the sequencer |
| cmd_code_o | output | 8 | Status command code |
| cmd_ready_i | input | 1 | Sequencer accepts the command |
| rd_req_o | output | 1 | Byte read request |
| rd_valid_i | input | 1 | Read byte is valid this cycle |
| rd_data_i | input | 8 | Read byte |
| rb_ready_i | input | 1 | Ready/busy pin, high when ready (synchronous) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final status captured |
| status_o | output | 8 | Final status byte |
| fail_o | output | 1 | Operation failed (status bit 0) |
| timeout_o | output | 1 | Timeout expired before ready |

## Verification
The bench stretches the busy time beyond both timeout limits, once in pin mode and once in polling mode. A block that picked the wrong limit, or counted from the wrong cycle, would finish at a different cycle than the reference model. A block that stopped on timeout without the final read would never raise `done_o`. Polling runs return several not-ready bytes before a ready one: a design that took any returned byte as ready would finish early and do only one poll. The bench also raises start in the middle of a wait with a different operation type. A block that relatched it would show the multi-plane code or the erase timeout. Finally, every cycle of the settle window is compared, so a read issued early or a flag that changes while idle is caught.

// File: rtl/nwait_pkg.sv
package nwait_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_WAIT,
      ST_SETTLE,
      ST_READ
   } nwait_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nwait_timebase.sv
// Millisecond tick prescaler: one tick every DIV enabled cycles.
module nwait_timebase #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_direct
         logic unused_direct;
         assign unused_direct = ^{clk_i, rst_ni};
         assign tick_o = !clr_i;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni || clr_i) pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else pre_q <= pre_q + 1'b1;
         end

         assign tick_o = !clr_i && (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/nwait_tick_counter.sv
// Saturating tick counter compared against a selectable limit.
module nwait_tick_counter #(
   parameter int unsigned W = 9
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) cnt_q <= '0;
      else if (tick_i && (cnt_q != limit_i)) cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/nand_op_waiter.sv
module nand_op_waiter
   import nwait_pkg::*;
#(
   parameter int unsigned CLK_KHZ       = 250000,
   parameter int unsigned ERASE_MS      = 400,
   parameter int unsigned PROG_MS       = 20,
   parameter int unsigned SETTLE_TICKS  = 10,
   parameter logic [7:0]  CMD_STATUS    = 8'h70,
   parameter logic [7:0]  CMD_STATUS_MP = 8'h71,
   parameter int unsigned READY_BIT     = 6,
   parameter int unsigned FAIL_BIT      = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       op_erase_i,
   input  logic       multi_plane_i,
   input  logic       use_rb_i,
   output logic       cmd_valid_o,
   output logic [7:0] cmd_code_o,
   input  logic       cmd_ready_i,
   output logic       rd_req_o,
   input  logic       rd_valid_i,
   input  logic [7:0] rd_data_i,
   input  logic       rb_ready_i,
   output logic       busy_o,
   output logic       done_o,
   output logic [7:0] status_o,
   output logic       fail_o,
   output logic       timeout_o
);
   localparam int unsigned LIM_MAX = max3(ERASE_MS, PROG_MS, SETTLE_TICKS);
   localparam int unsigned CW      = $clog2(LIM_MAX + 1);

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("CLK_KHZ must be at least 1");
      end
      if (ERASE_MS < 1 || PROG_MS < 1 || SETTLE_TICKS < 1) begin : g_bad_lim
         $error("timeout and settle limits must be at least 1");
      end
      if (READY_BIT > 7 || FAIL_BIT > 7 || READY_BIT == FAIL_BIT) begin : g_bad_bits
         $error("status bit positions must be distinct and below 8");
      end
   endgenerate

   nwait_state_e state_q;
   logic         erase_q, mp_q, use_rb_q;
   logic [7:0]   status_q;
   logic         fail_q, tmo_q, done_q;

   logic         in_wait, in_settle;
   logic         ready_seen, resp_seen, wait_exit;
   logic         cnt_clr, tick, cnt_hit;
   logic [CW-1:0] limit;

   assign in_wait    = (state_q == ST_WAIT);
   assign in_settle  = (state_q == ST_SETTLE);
   assign resp_seen  = use_rb_q ? 1'b1 : rd_valid_i;
   assign ready_seen = use_rb_q ? rb_ready_i : (rd_valid_i && rd_data_i[READY_BIT]);
   assign wait_exit  = in_wait && (ready_seen || (cnt_hit && resp_seen));
   assign cnt_clr    = !(in_wait || in_settle) || wait_exit;
   assign limit      = in_settle ? CW'(SETTLE_TICKS)
                                 : (erase_q ? CW'(ERASE_MS) : CW'(PROG_MS));

   nwait_timebase #(.DIV(CLK_KHZ)) u_tb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .tick_o (tick)
   );

   nwait_tick_counter #(.W(CW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cnt_clr),
      .tick_i  (tick),
      .limit_i (limit),
      .hit_o   (cnt_hit)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         erase_q  <= 1'b0;
         mp_q     <= 1'b0;
         use_rb_q <= 1'b0;
         status_q <= '0;
         fail_q   <= 1'b0;
         tmo_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               erase_q  <= op_erase_i;
               mp_q     <= multi_plane_i;
               use_rb_q <= use_rb_i;
               status_q <= '0;
               fail_q   <= 1'b0;
               tmo_q    <= 1'b0;
               done_q   <= 1'b0;
               state_q  <= ST_CMD;
            end
            ST_CMD: if (cmd_ready_i) state_q <= ST_WAIT;
            ST_WAIT: if (wait_exit) begin
               state_q <= ST_SETTLE;
               if (!ready_seen) tmo_q <= 1'b1;
            end
            ST_SETTLE: if (cnt_hit) state_q <= ST_READ;
            ST_READ: if (rd_valid_i) begin
               status_q <= rd_data_i;
               fail_q   <= rd_data_i[FAIL_BIT];
               done_q   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid_o = (state_q == ST_CMD);
   assign cmd_code_o  = (erase_q && mp_q) ? CMD_STATUS_MP : CMD_STATUS;
   assign rd_req_o    = (in_wait && !use_rb_q) || (state_q == ST_READ);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign status_o    = status_q;
   assign fail_o      = fail_q;
   assign timeout_o   = tmo_q;

   // R1: request and code held until accepted
   a_r1_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o));

   // R5: timeout flag only rises after the limit counter reached its limit
   a_r5_tmo_after_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timeout_o) |-> $past(cnt_hit));

   // R6: final read only after the settle count completes
   a_r6_settle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_READ && $past(state_q) == ST_SETTLE) |-> $past(cnt_hit));

   // R7: pass/fail flag agrees with the captured byte
   a_r7_fail_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (fail_o == status_o[FAIL_BIT]));

   // R8: results stay put while idle
   a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && !start_i |=> $stable(status_o) && $stable(fail_o)
                              && $stable(timeout_o) && $stable(done_o));

   // R9: operation settings not relatched while busy
   a_r9_no_relatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && start_i |=> $stable(erase_q) && $stable(mp_q) && $stable(use_rb_q));

endmodule

// File: tb/sim_nand_op_waiter.sv
module sim_nand_op_waiter;
   localparam int K      = 3;
   localparam int ERASE  = 400;
   localparam int PROG   = 20;
   localparam int SETTLE = 10;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic start_i = 1'b0, op_erase_i = 1'b0, multi_plane_i = 1'b0, use_rb_i = 1'b1;
   logic cmd_valid_o, cmd_ready_i = 1'b0;
   logic [7:0] cmd_code_o;
   logic rd_req_o, rd_valid_i = 1'b0;
   logic [7:0] rd_data_i = 8'h00;
   logic rb_ready_i = 1'b1;
   logic busy_o, done_o, fail_o, timeout_o;
   logic [7:0] status_o;

   always #2 clk = ~clk;

   nand_op_waiter #(
      .CLK_KHZ(K), .ERASE_MS(ERASE), .PROG_MS(PROG), .SETTLE_TICKS(SETTLE)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_erase_i(op_erase_i),
      .multi_plane_i(multi_plane_i), .use_rb_i(use_rb_i),
      .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o), .cmd_ready_i(cmd_ready_i),
      .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .rb_ready_i(rb_ready_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
      .fail_o(fail_o), .timeout_o(timeout_o)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // flash and sequencer responders
   int  flash_busy = 0;
   bit  flash_fail = 0;
   int  cmd_lat = 0, cmd_cnt = 0;
   int  last_code = 0, rd_resp = 0;

   // behavioural reference model
   int  m_phase = 0, m_n = 0;
   bit  m_erase = 0, m_mp = 0, m_rb = 0, m_fail = 0, m_tmo = 0, m_done = 0;
   int  m_status = 0;

   always @(posedge clk) begin
      if (!rst_ni) begin
         m_phase = 0; m_n = 0; m_status = 0;
         m_fail = 0; m_tmo = 0; m_done = 0;
      end else begin
         case (m_phase)
            0: if (start_i) begin
               m_erase = op_erase_i; m_mp = multi_plane_i; m_rb = use_rb_i;
               m_status = 0; m_fail = 0; m_tmo = 0; m_done = 0; m_phase = 1;
            end
            1: if (cmd_ready_i) begin m_phase = 2; m_n = 0; end
            2: begin
               bit rdy, resp, expired;
               expired = m_n >= (m_erase ? ERASE : PROG) * K;
               rdy  = m_rb ? rb_ready_i : (rd_valid_i && rd_data_i[6]);
               resp = m_rb || rd_valid_i;
               if (rdy) begin m_phase = 3; m_n = 0; end
               else if (expired && resp) begin m_tmo = 1; m_phase = 3; m_n = 0; end
               else m_n++;
            end
            3: if (m_n >= SETTLE * K) m_phase = 4; else m_n++;
            default: if (rd_valid_i) begin
               m_status = int'(rd_data_i); m_fail = rd_data_i[0];
               m_done = 1; m_phase = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_ni) begin
         chk(busy_o === (m_phase != 0), "R1 R9 busy_o", int'(busy_o), int'(m_phase != 0));
         chk(cmd_valid_o === (m_phase == 1), "R1 cmd_valid_o", int'(cmd_valid_o), int'(m_phase == 1));
         if (m_phase == 1)
            chk(int'(cmd_code_o) == ((m_erase && m_mp) ? 8'h71 : 8'h70), "R2 cmd_code_o",
                int'(cmd_code_o), (m_erase && m_mp) ? 8'h71 : 8'h70);
         chk(rd_req_o === ((m_phase == 2 && !m_rb) || m_phase == 4), "R3 R4 R6 rd_req_o",
             int'(rd_req_o), int'((m_phase == 2 && !m_rb) || m_phase == 4));
         chk(timeout_o === m_tmo, "R5 timeout_o", int'(timeout_o), int'(m_tmo));
         chk(done_o === m_done, "R7 R8 done_o", int'(done_o), int'(m_done));
         chk(int'(status_o) == m_status, "R7 R8 status_o", int'(status_o), m_status);
         chk(fail_o === m_fail, "R7 R8 fail_o", int'(fail_o), int'(m_fail));
      end
      // drive responders for the next edge
      if (flash_busy > 0) flash_busy--;
      rb_ready_i = (flash_busy == 0);
      if (cmd_valid_o) cmd_cnt++; else cmd_cnt = 0;
      cmd_ready_i = cmd_valid_o && (cmd_cnt > cmd_lat);
      if (cmd_ready_i) last_code = int'(cmd_code_o);
      rd_valid_i = rd_req_o && !rd_valid_i;
      rd_data_i  = {1'b0, (flash_busy == 0), 5'b0, flash_fail};
      if (rd_valid_i) rd_resp++;
   end

   task automatic launch(input bit er, input bit mp, input bit rb, input int bsy,
                         input bit fl, input int lat);
      @(negedge clk);
      flash_busy = bsy; flash_fail = fl; cmd_lat = lat; rd_resp = 0; last_code = 0;
      op_erase_i = er; multi_plane_i = mp; use_rb_i = rb; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0 && status_o == 8'h00 && timeout_o == 1'b0,
          "R8 cleared by start", int'({done_o, timeout_o, status_o}), 0);
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         cyc++;
         if (done_o) break;
      end
   endtask

   initial begin
      int cyc;
      logic [7:0] keep;
      repeat (5) @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0 && status_o == 8'h00 && timeout_o == 1'b0,
          "R1 R8 reset state", int'({busy_o, done_o, timeout_o, status_o}), 0);
      rst_ni = 1'b1;
      repeat (3) @(negedge clk);

      // program, pin mode, passes
      launch(0, 0, 1, 40, 0, 2);
      wait_done(cyc);
      chk(done_o == 1'b1, "R7 program done", int'(done_o), 1);
      chk(status_o == 8'h40 && fail_o == 1'b0, "R7 program pass status",
          int'(status_o), 8'h40);
      chk(timeout_o == 1'b0, "R5 no timeout", int'(timeout_o), 0);
      chk(last_code == 8'h70, "R2 program code", last_code, 8'h70);
      chk(rd_resp == 1, "R3 only final read in pin mode", rd_resp, 1);
      keep = status_o;
      repeat (20) @(negedge clk);
      chk(status_o == keep && done_o == 1'b1, "R8 hold while idle", int'(status_o), int'(keep));

      // erase, multi-plane, pin mode, fails
      launch(1, 1, 1, 100, 1, 0);
      wait_done(cyc);
      chk(last_code == 8'h71, "R2 multi-plane erase code", last_code, 8'h71);
      chk(status_o == 8'h41 && fail_o == 1'b1, "R7 erase fail bit", int'(status_o), 8'h41);

      // program, multi-plane flag set: normal code
      launch(0, 1, 1, 10, 0, 1);
      wait_done(cyc);
      chk(last_code == 8'h70, "R2 multi-plane program code", last_code, 8'h70);

      // erase, polling mode
      launch(1, 0, 0, 50, 1, 0);
      wait_done(cyc);
      chk(rd_resp > 3, "R4 repeated polls", rd_resp, 4);
      chk(fail_o == 1'b1 && timeout_o == 1'b0, "R4 R7 polled erase result",
          int'({fail_o, timeout_o}), 2);

      // program timeout, pin mode
      launch(0, 0, 1, 5000, 0, 0);
      wait_done(cyc);
      chk(timeout_o == 1'b1 && done_o == 1'b1, "R5 program timeout then final read",
          int'({timeout_o, done_o}), 3);
      chk(status_o == 8'h00, "R5 R7 busy status read after timeout", int'(status_o), 0);
      chk(cyc >= (PROG + SETTLE) * K && cyc < (PROG + SETTLE) * K + 12,
          "R5 R6 program timeout length", cyc, (PROG + SETTLE) * K);

      // erase timeout, polling mode
      launch(1, 0, 0, 5000, 0, 0);
      wait_done(cyc);
      chk(timeout_o == 1'b1, "R5 erase timeout polled", int'(timeout_o), 1);
      chk(cyc >= (ERASE + SETTLE) * K, "R5 erase limit longer", cyc, (ERASE + SETTLE) * K);

      // start while busy is ignored
      launch(0, 0, 1, 5000, 0, 0);
      repeat (20) @(negedge clk);
      op_erase_i = 1'b1; multi_plane_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(cyc);
      chk(last_code == 8'h70, "R9 code of running op kept", last_code, 8'h70);
      chk(timeout_o == 1'b1 && cyc + 21 < (PROG + SETTLE) * K + 12,
          "R9 program limit kept", cyc + 21, (PROG + SETTLE) * K);

      repeat (5) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule